// File: doc/BRIEF.md
# Supply Reset Supervisor Timer

This block turns a digital "supply is above the reset threshold" flag and a regulator enable into an active-low reset for a processor. While the supply flag is low, the reset output is held asserted. After the flag returns high, the reset output stays asserted for a minimum hold-off window before it releases. The analog comparator that produces the flag is outside the block, and so is any hysteresis. The capacitor-based timing of a discrete supervisor is replaced by a clock counter.

The hold-off window is set by two parameters. One is the number of clock cycles in one timing step, which stands for 2.5 ms of capacitor setting. The other is the number of such steps. The window length is their product. With the defaults, ten steps give the nominal 25 ms.

The enable input has two further effects. While the regulator is disabled, the reset output is kept released. Each time the regulator is switched on, the block issues a full-length reset pulse. Both inputs are taken as synchronous to the clock.

Top module: `supply_reset_supervisor`

## Requirements
- R1: During and directly after the synchronous block reset `rst`, `reset_n` is 0.
- R2: At every clock edge that samples `en` = 0, `reset_n` becomes 1, whatever the value of `vin_ok`.
- R3: At every clock edge that samples `en` = 1 and `vin_ok` = 0, `reset_n` becomes 0.
- R4: When an edge samples `en` rising (0 at the previous edge, 1 now) with `vin_ok` = 1, `reset_n` goes to 0 at that edge. It stays 0 for exactly TIMEOUT = STEP_CYCLES * TIMEOUT_STEPS cycles and returns to 1 at the TIMEOUT-th edge after it.
- R5: If `vin_ok` is 0 when `en` rises, `reset_n` stays 0. It returns to 1 at the TIMEOUT-th edge after the last edge that sampled `vin_ok` = 0.
- R6: A drop of `vin_ok` while a hold-off window is running forces `reset_n` to 0. A full window is then restarted from the recovery.
- R7: The internal window counter never exceeds TIMEOUT-1, and the window length follows the product of the two parameters.
- R8: Once released, `reset_n` stays 1 with no glitch for as long as `en` and `vin_ok` stay 1.
- R9: If `en` falls during a window, `reset_n` becomes 1 at the next edge. A later rise of `en` starts a full new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| en | input | 1 | Regulator enable, active high |
| vin_ok | input | 1 | Supply above reset threshold, with hysteresis applied upstream |
| reset_n | output | 1 | Registered active-low processor reset |

## Verification
The bench builds the block with STEP_CYCLES = 3 and TIMEOUT_STEPS = 4, so the window is 12 cycles. This keeps every window short enough to walk through edge by edge. Exact pulse lengths can therefore be counted for an enable rise, for a supply recovery, and for a restart after a dip in the middle of a window. An enable drop in the middle of a window is covered too. The gap of one edge between an enable-started window and a recovery-started window is checked directly.

// File: rtl/sup_pkg.sv
package sup_pkg;

  function automatic int unsigned timeout_cycles(input int unsigned step_cycles,
                                                 input int unsigned steps);
    return step_cycles * steps;
  endfunction

  function automatic int unsigned count_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sup_en_edge.sv
module sup_en_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rise
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  assign rise = en & ~en_q;

endmodule

// File: rtl/sup_timeout.sv
module sup_timeout #(
  parameter int unsigned TIMEOUT = 12,
  parameter int unsigned W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic restart,
  output logic busy,
  output logic expire
);
  localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (restart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign expire = busy & ~abort & ~restart & (cnt == LAST);

  // R7: window counter stays inside the window
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R7: an idle counter rests at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cnt == '0);

endmodule

// File: rtl/sup_reset_drive.sv
module sup_reset_drive (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  input  logic busy,
  input  logic expire,
  output logic reset_n
);
  logic reset_n_q;

  always_ff @(posedge clk) begin
    if (rst)          reset_n_q <= 1'b0;
    else if (!en)     reset_n_q <= 1'b1;
    else if (restart) reset_n_q <= 1'b0;
    else if (busy)    reset_n_q <= expire;
    else              reset_n_q <= 1'b1;
  end

  assign reset_n = reset_n_q;

  // R1: block reset asserts the output
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !reset_n_q);

  // R2: disabled regulator releases reset
  a_r2_disabled_high: assert property (@(posedge clk) disable iff (rst)
    !en |=> reset_n_q);

endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor #(
  parameter int unsigned STEP_CYCLES   = 250000,
  parameter int unsigned TIMEOUT_STEPS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vin_ok,
  output logic reset_n
);
  localparam int unsigned TIMEOUT = sup_pkg::timeout_cycles(STEP_CYCLES, TIMEOUT_STEPS);
  localparam int unsigned W       = sup_pkg::count_width(TIMEOUT);

  logic en_rise;
  logic restart;
  logic abort;
  logic busy;
  logic expire;

  sup_en_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .rise (en_rise)
  );

  assign restart = en & (~vin_ok | en_rise);
  assign abort   = ~en;

  sup_timeout #(
    .TIMEOUT (TIMEOUT),
    .W       (W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .abort   (abort),
    .restart (restart),
    .busy    (busy),
    .expire  (expire)
  );

  sup_reset_drive u_drv (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .restart (restart),
    .busy    (busy),
    .expire  (expire),
    .reset_n (reset_n)
  );

  // R3: supply below threshold with regulator on asserts reset
  a_r3_brownout_low: assert property (@(posedge clk) disable iff (rst)
    en && !vin_ok |=> !reset_n);

  // R4: enable rising edge starts a pulse
  a_r4_pulse_start: assert property (@(posedge clk) disable iff (rst)
    $rose(en) && vin_ok |=> !reset_n);

  // R6: release with the regulator on only after a good supply sample
  a_r6_release_needs_supply: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_n) && $past(en) |-> $past(vin_ok));

endmodule

// File: tb/sim_supply_reset_supervisor.sv
module sim_supply_reset_supervisor;
  localparam int unsigned STEP_CYCLES   = 3;
  localparam int unsigned TIMEOUT_STEPS = 4;
  localparam int          T             = STEP_CYCLES * TIMEOUT_STEPS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic vin_ok = 1'b0;
  logic reset_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supply_reset_supervisor #(
    .STEP_CYCLES   (STEP_CYCLES),
    .TIMEOUT_STEPS (TIMEOUT_STEPS)
  ) u0 (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .vin_ok  (vin_ok),
    .reset_n (reset_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_level(input logic lvl, input string tag);
    check(reset_n === lvl, tag, int'(reset_n), int'(lvl));
  endtask

  // n edges with reset_n low, then the next edge releases it
  task automatic check_pulse(input int n, input string tag);
    int low_cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (reset_n === 1'b0) low_cnt++;
    end
    check(low_cnt == n, {tag, " low length"}, low_cnt, n);
    tick();
    expect_level(1'b1, {tag, " release"});
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; vin_ok = 1'b0;
    repeat (3) tick();
    expect_level(1'b0, "R1 during rst");
    rst = 1'b0;
    expect_level(1'b0, "R1 after rst");
  endtask

  task automatic t_disabled();
    en = 1'b0; vin_ok = 1'b0;
    tick();
    expect_level(1'b1, "R2 en low vin low");
    vin_ok = 1'b1; tick();
    expect_level(1'b1, "R2 en low vin high");
    vin_ok = 1'b0; tick();
    expect_level(1'b1, "R2 en low vin toggled");
  endtask

  task automatic t_enable_pulse();
    vin_ok = 1'b1; tick();
    en = 1'b1;
    check_pulse(T, "R4 R7 enable pulse");
  endtask

  task automatic t_steady();
    int highs = 0;
    for (int i = 0; i < 3 * T; i++) begin
      tick();
      if (reset_n === 1'b1) highs++;
    end
    check(highs == 3 * T, "R8 steady high", highs, 3 * T);
  endtask

  task automatic t_brownout();
    vin_ok = 1'b0; tick();
    expect_level(1'b0, "R3 supply drop");
    tick(); tick();
    expect_level(1'b0, "R3 supply still low");
    vin_ok = 1'b1;
    check_pulse(T - 1, "R3 recovery window");
  endtask

  task automatic t_enable_while_low();
    en = 1'b0; vin_ok = 1'b0; tick();
    expect_level(1'b1, "R5 disabled before");
    en = 1'b1; tick();
    expect_level(1'b0, "R5 enable with low supply");
    repeat (2 * T) tick();
    expect_level(1'b0, "R5 held while supply low");
    vin_ok = 1'b1;
    check_pulse(T - 1, "R5 recovery window");
  endtask

  task automatic t_dip_restart();
    en = 1'b0; vin_ok = 1'b1; tick();
    en = 1'b1;
    repeat (5) tick();
    expect_level(1'b0, "R6 mid window");
    vin_ok = 1'b0; tick(); tick();
    expect_level(1'b0, "R6 dip");
    vin_ok = 1'b1;
    check_pulse(T - 1, "R6 restarted window");
  endtask

  task automatic t_enable_drop();
    en = 1'b0; tick();
    en = 1'b1;
    repeat (4) tick();
    en = 1'b0; tick();
    expect_level(1'b1, "R9 enable drop releases");
    en = 1'b1;
    check_pulse(T, "R9 fresh window");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable_pulse();
    t_steady();
    t_brownout();
    t_enable_while_low();
    t_dip_restart();
    t_enable_drop();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule